// File: doc/BRIEF.md
# 32-bit Shift Unit with Carry

This block executes the word-shift group of a fixed-point execution pipe. It shifts a 32-bit source word left or right with zero fill, or right with sign fill, by an amount taken either from a register operand or from a 5-bit immediate. For the sign-filling shifts it also computes the carry flag, which reports whether a negative word lost any one bits. The operation is chosen by the 10-bit extended opcode that the instruction decoder already extracts.

The register-derived amount is 6 bits wide. When its top bit is set, the shift is out of range. In that case the zero-filling shifts return zero and the sign-filling shift returns a word made entirely of the sign bit. Result, carry and a carry write strobe are registered, so they appear one cycle after a valid request. The strobe tells the flag file to update its carry bit. Zero-filling shifts never raise the strobe.

Top module: `shift_ca_unit`

## Requirements
- R1: A valid request whose op_code is one of 24, 536, 792 or 824 raises out_valid exactly one cycle later. Any other code, or an idle cycle, gives out_valid = 0 and ca_we = 0 in the following cycle.
- R2: Code 24 (left, zero fill) with amt_reg[5] = 0 gives src shifted left by amt_reg[4:0].
- R3: Code 536 (right, zero fill) with amt_reg[5] = 0 gives src shifted right by amt_reg[4:0].
- R4: Codes 24 and 536 with amt_reg[5] = 1 give a result of zero, whatever the low amount bits are.
- R5: Code 792 (right, sign fill, register amount) with an amount of 1 to 31 gives the sign-filled shift. ca = 1 exactly when src[31] = 1 and at least one 1 bit was shifted out.
- R6: Code 792 with amt_reg[5] = 1 gives 32 copies of src[31]. ca = src[31] AND (any of src[30:0] set).
- R7: Code 824 (right, sign fill, immediate amount) shifts by amt_imm with the same carry rule as R5, and ignores amt_reg. amt_imm = 0 returns src unchanged with ca = 0.
- R8: Code 792 with amt_reg = 0 returns src unchanged with ca = 0.
- R9: ca_we is 1 in the cycle after a code 792 or 824 request and 0 otherwise. After a zero-fill shift, the ca output keeps its previous value.
- R10: After reset, out_valid, ca_we, ca and result are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op_code | input | 10 | Extended opcode selecting the shift |
| src | input | 32 | Source word |
| amt_reg | input | 6 | Register-derived shift amount; bit 5 means out of range |
| amt_imm | input | 5 | Immediate shift amount for code 824 |
| out_valid | output | 1 | Registered result is valid |
| result | output | 32 | Registered shifted word |
| ca | output | 1 | Registered carry flag |
| ca_we | output | 1 | Carry write strobe, high only for sign-fill shifts |

## Verification
The bench targets the amount boundaries: 0, 31, 32 and 63 on the register path, and 0 and 31 on the immediate path. A design that used only five amount bits would wrap 32 to a zero shift and return the source. A design that counted the sign bit, or ignored it, in the out-of-range carry would report the wrong flag for 0x80000000 and 0x80000001. Negative words whose shifted-out bits are all zero check that the carry does not follow the sign alone. Immediate shifts are applied with a junk register amount, to catch a unit that selects the wrong amount source. A zero-fill shift after a carry-setting one checks that the flag is neither rewritten nor strobed.

// File: rtl/shu_pkg.sv
package shu_pkg;
  localparam int XO_W = 10;
  localparam logic [XO_W-1:0] XO_SHL  = 10'd24;
  localparam logic [XO_W-1:0] XO_SHR  = 10'd536;
  localparam logic [XO_W-1:0] XO_SAR  = 10'd792;
  localparam logic [XO_W-1:0] XO_SARI = 10'd824;

  typedef enum logic [2:0] {
    OP_NONE, OP_SHL, OP_SHR, OP_SAR, OP_SARI
  } shu_op_e;
endpackage

// File: rtl/shu_decode.sv
module shu_decode
  import shu_pkg::*;
#(
  parameter int SHW = 5
) (
  input  logic [XO_W-1:0] op_code,
  input  logic [SHW:0]    amt_reg,
  input  logic [SHW-1:0]  amt_imm,
  output shu_op_e         op,
  output logic [SHW-1:0]  sh,
  output logic            oor,
  output logic            go_left,
  output logic            arith
);
  always_comb begin
    case (op_code)
      XO_SHL:  op = OP_SHL;
      XO_SHR:  op = OP_SHR;
      XO_SAR:  op = OP_SAR;
      XO_SARI: op = OP_SARI;
      default: op = OP_NONE;
    endcase
  end

  // Immediate form has no out-of-range bit.
  assign sh      = (op == OP_SARI) ? amt_imm : amt_reg[SHW-1:0];
  assign oor     = (op != OP_SARI) && amt_reg[SHW];
  assign go_left = (op == OP_SHL);
  assign arith   = (op == OP_SAR) || (op == OP_SARI);
endmodule

// File: rtl/shu_barrel.sv
module shu_barrel #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] sh,
  input  logic           go_left,
  input  logic           fill,
  input  logic           oor,
  output logic [W-1:0]   dout
);
  logic [W-1:0] pre;
  logic [W-1:0] post;
  logic [W-1:0] stg [0:SHW];

  // Left shifts reuse the right shifter on a bit-reversed word.
  always_comb begin
    for (int i = 0; i < W; i++) pre[i] = go_left ? din[W-1-i] : din[i];
  end

  assign stg[0] = pre;
  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int S = 2 ** k;
    assign stg[k+1] = sh[k] ? {{S{fill}}, stg[k][W-1:S]} : stg[k];
  end

  assign post = oor ? {W{fill}} : stg[SHW];

  always_comb begin
    for (int i = 0; i < W; i++) dout[i] = go_left ? post[W-1-i] : post[i];
  end
endmodule

// File: rtl/shu_carry.sv
module shu_carry #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] sh,
  input  logic           oor,
  output logic           ca
);
  logic [W-1:0] lost_mask;
  logic         lost_ones;

  assign lost_mask = ~({W{1'b1}} << sh);
  assign lost_ones = oor ? |din[W-2:0] : |(din & lost_mask);
  assign ca        = din[W-1] & lost_ones;
endmodule

// File: rtl/shift_ca_unit.sv
module shift_ca_unit
  import shu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [9:0]           op_code,
  input  logic [W-1:0]         src,
  input  logic [$clog2(W):0]   amt_reg,
  input  logic [$clog2(W)-1:0] amt_imm,
  output logic                 out_valid,
  output logic [W-1:0]         result,
  output logic                 ca,
  output logic                 ca_we
);
  localparam int SHW = $clog2(W);

  shu_op_e        op;
  logic [SHW-1:0] sh;
  logic           oor, go_left, arith;
  logic [W-1:0]   shifted;
  logic           ca_next;

  shu_decode #(.SHW(SHW)) u_dec (
    .op_code(op_code), .amt_reg(amt_reg), .amt_imm(amt_imm),
    .op(op), .sh(sh), .oor(oor), .go_left(go_left), .arith(arith)
  );

  shu_barrel #(.W(W), .SHW(SHW)) u_bar (
    .din(src), .sh(sh), .go_left(go_left),
    .fill(arith & src[W-1]), .oor(oor), .dout(shifted)
  );

  shu_carry #(.W(W), .SHW(SHW)) u_ca (
    .din(src), .sh(sh), .oor(oor), .ca(ca_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      ca_we     <= 1'b0;
      result    <= '0;
      ca        <= 1'b0;
    end else begin
      out_valid <= in_valid && (op != OP_NONE);
      ca_we     <= in_valid && arith;
      if (in_valid && (op != OP_NONE)) result <= shifted;
      if (in_valid && arith) ca <= ca_next;
    end
  end

  // R1: unrecognised or idle cycles produce nothing
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || op_code == 10'd0) |=> (!out_valid && !ca_we));

  // R4: out-of-range zero-fill shift yields zero
  p_oor_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_code == XO_SHL || op_code == XO_SHR) && amt_reg[SHW])
      |=> (out_valid && result == '0));

  // R9: strobe follows sign-fill requests, never zero-fill ones
  p_we_arith_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_code == XO_SAR || op_code == XO_SARI)) |=> ca_we);
  p_we_logic_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_code == XO_SHL || op_code == XO_SHR)) |=> (!ca_we && $stable(ca)));

  // R5: a carry is only reported for a negative source, whose sign survives
  p_ca_neg_r5: assert property (@(posedge clk) disable iff (rst)
    (ca_we && ca) |-> result[W-1]);

  // R8: zero register amount on sign-fill shift passes the word through
  p_zero_amt_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == XO_SAR && amt_reg == '0) |=> (result == $past(src) && !ca));
endmodule

// File: tb/sim_shift_ca_unit.sv
module sim_shift_ca_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [9:0]  op_code;
  logic [31:0] src;
  logic [5:0]  amt_reg;
  logic [4:0]  amt_imm;
  logic        out_valid, ca, ca_we;
  logic [31:0] result;

  int vecs = 0;
  int errs = 0;

  always #10 clk = ~clk;  // 50 MHz

  shift_ca_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
    .src(src), .amt_reg(amt_reg), .amt_imm(amt_imm),
    .out_valid(out_valid), .result(result), .ca(ca), .ca_we(ca_we)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one request at a falling edge; outputs are sampled after the next rising edge.
  task automatic issue(input logic [9:0] c, input logic [31:0] s,
                       input logic [5:0] ar, input logic [4:0] ai);
    @(negedge clk);
    in_valid = 1'b1; op_code = c; src = s; amt_reg = ar; amt_imm = ai;
    @(posedge clk); #5;
    in_valid = 1'b0;
  endtask

  // Sign-fill expectation from the requirements.
  task automatic sar_expect(input logic [31:0] s, input int n, input bit oor,
                            output logic [31:0] r, output logic c);
    if (oor) begin
      r = {32{s[31]}};
      c = s[31] && (s[30:0] != 0);
    end else begin
      r = $unsigned($signed(s) >>> n);
      c = 1'b0;
      for (int i = 0; i < n; i++) if (s[i]) c = s[31];
    end
  endtask

  task automatic t_reset();
    chk("R10 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R10 ca_we", {31'd0, ca_we}, 32'd0);
    chk("R10 ca", {31'd0, ca}, 32'd0);
    chk("R10 result", result, 32'd0);
  endtask

  task automatic t_logical();
    issue(10'd24, 32'h8000_0001, 6'd4, 5'd0);
    chk("R2 shl", result, 32'h0000_0010);
    chk("R1 valid", {31'd0, out_valid}, 32'd1);
    issue(10'd24, 32'hDEAD_BEEF, 6'd31, 5'd0);
    chk("R2 shl31", result, 32'h8000_0000);
    issue(10'd536, 32'hF000_000F, 6'd3, 5'd0);
    chk("R3 shr", result, 32'h1E00_0001);
    issue(10'd536, 32'hFFFF_FFFF, 6'd0, 5'd7);
    chk("R3 shr0", result, 32'hFFFF_FFFF);
    issue(10'd24, 32'hFFFF_FFFF, 6'd32, 5'd0);
    chk("R4 shl32", result, 32'd0);
    issue(10'd536, 32'hFFFF_FFFF, 6'd63, 5'd0);
    chk("R4 shr63", result, 32'd0);
  endtask

  task automatic t_sar_reg();
    logic [31:0] r; logic c;
    logic [31:0] s [6] = '{32'h8000_0010, 32'h8000_0018, 32'h7FFF_FFFF,
                           32'hFFFF_FFFF, 32'h8000_0000, 32'hC000_0001};
    int n [6] = '{4, 4, 31, 31, 1, 30};
    for (int i = 0; i < 6; i++) begin
      issue(10'd792, s[i], 6'(n[i]), 5'd0);
      sar_expect(s[i], n[i], 1'b0, r, c);
      chk("R5 result", result, r);
      chk("R5 ca", {31'd0, ca}, {31'd0, c});
      chk("R9 we", {31'd0, ca_we}, 32'd1);
    end
  endtask

  task automatic t_sar_oor();
    logic [31:0] r; logic c;
    logic [31:0] s [3] = '{32'h8000_0000, 32'h8000_0001, 32'h7FFF_FFFF};
    for (int i = 0; i < 3; i++) begin
      issue(10'd792, s[i], 6'd40, 5'd0);
      sar_expect(s[i], 0, 1'b1, r, c);
      chk("R6 result", result, r);
      chk("R6 ca", {31'd0, ca}, {31'd0, c});
    end
  endtask

  task automatic t_sar_imm();
    logic [31:0] r; logic c;
    issue(10'd824, 32'h8000_0003, 6'd63, 5'd1);
    sar_expect(32'h8000_0003, 1, 1'b0, r, c);
    chk("R7 result", result, r);
    chk("R7 ca", {31'd0, ca}, {31'd0, c});
    issue(10'd824, 32'hFFFF_FFFF, 6'd63, 5'd0);
    chk("R7 imm0 result", result, 32'hFFFF_FFFF);
    chk("R7 imm0 ca", {31'd0, ca}, 32'd0);
    issue(10'd824, 32'hFFFF_FFFF, 6'd0, 5'd31);
    chk("R7 imm31 result", result, 32'hFFFF_FFFF);
    chk("R7 imm31 ca", {31'd0, ca}, 32'd1);
  endtask

  task automatic t_zero_amt();
    issue(10'd792, 32'h8765_4321, 6'd0, 5'd9);
    chk("R8 result", result, 32'h8765_4321);
    chk("R8 ca", {31'd0, ca}, 32'd0);
  endtask

  task automatic t_ca_hold();
    issue(10'd792, 32'h8000_0001, 6'd1, 5'd0);
    chk("R9 set ca", {31'd0, ca}, 32'd1);
    issue(10'd536, 32'h0000_0001, 6'd1, 5'd0);
    chk("R9 ca held", {31'd0, ca}, 32'd1);
    chk("R9 no we", {31'd0, ca_we}, 32'd0);
    issue(10'd24, 32'h0000_0001, 6'd40, 5'd0);
    chk("R9 ca held2", {31'd0, ca}, 32'd1);
  endtask

  task automatic t_unknown();
    issue(10'd536, 32'h1234_5678, 6'd4, 5'd0);
    issue(10'd1023, 32'hFFFF_FFFF, 6'd1, 5'd1);
    chk("R1 bad code valid", {31'd0, out_valid}, 32'd0);
    chk("R1 bad code we", {31'd0, ca_we}, 32'd0);
    @(posedge clk); #5;
    chk("R1 idle valid", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; op_code = '0; src = '0; amt_reg = '0; amt_imm = '0;
    repeat (3) @(posedge clk);
    #5 t_reset();
    @(negedge clk) rst = 1'b0;
    t_logical();
    t_sar_reg();
    t_sar_oor();
    t_sar_imm();
    t_zero_amt();
    t_ca_hold();
    t_unknown();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule